// File: doc/BRIEF.md
# CBR Slot Host-Port Cell Dispatcher

This block runs each time the scheduler hands a constant-bit-rate slot to a connection. It reads that connection's segmentation word from a small connection table and checks whether the connection carries traffic from an external host port. If it does, and external scheduling is off, the block takes the host port number from the word and looks at that port's cell-availability count. The count comes from a bank of per-port shadow counters that sit outside the block.

When a cell is waiting, the block looks up the port's bus address in an internal address table. It raises one read request for a whole 52-byte cell, header included, and holds it until the bus acknowledges. It then sends a single-cycle decrement to that port's counter. The cell header is not taken from the connection word, the stored cell pointer is ignored and no rate matching is applied. A slot with an empty port ends with an empty-slot pulse. A port number that is out of range ends with an error pulse. A connection that is not a host stream ends with a skip pulse, so that the normal cell path can serve it.

Only one grant is handled at a time. The two tables are plain register arrays, each loaded through its own write strobe.

Top module: `hpd_cell_dispatch`

## Requirements
- R1: After reset, busy, read request, decrement, empty, error and skip outputs are all low, and both tables read as zero.
- R2: The host flag is bit 21 of the connection word and the port number is bits 30:26. A grant is sampled on a clock edge. If the flag is set, external scheduling is low, the port number is below NUM_PORTS and that port's count is non-zero, the read request rises after the second clock edge. At that point the address is the table address of that port and the length is 52.
- R3: While the read request is high and not acknowledged, it stays high and its address does not change.
- R4: After the edge that samples the acknowledge with the request high, the decrement output is one-hot on the granted port for exactly one cycle, and the request drops.
- R5: A port count of zero, for a valid host grant, gives a one-cycle empty pulse after the second edge, with no request and no decrement.
- R6: A port number of NUM_PORTS or more, on a host grant, gives a one-cycle error pulse after the second edge, with no request and no decrement.
- R7: If the host flag is clear, or external scheduling is high, the port number is not used. The grant ends with a one-cycle skip pulse after the second edge and raises no request, no error and no decrement, whatever the port field holds.
- R8: Busy is high from the edge that accepts a grant until the decrement or status pulse appears. Grants that arrive while busy is high are ignored.
- R9: The low ALIGN_BITS bits of the read address are always zero.
- R10: Connection-word bits outside the flag and the port field do not change the outcome or the read address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ext_sched_i | input | 1 | External-scheduling mode; high disables the port number |
| grant_valid_i | input | 1 | Scheduler grants a CBR slot |
| grant_conn_i | input | CONN_IW | Connection index of the grant |
| ctab_we_i | input | 1 | Connection table write strobe |
| ctab_idx_i | input | CONN_IW | Connection table write index |
| ctab_wdata_i | input | WORD_W | Connection word to store |
| atab_we_i | input | 1 | Address table write strobe |
| atab_idx_i | input | PIDX_W | Address table port index (out-of-range writes dropped) |
| atab_wdata_i | input | ADDR_W | Port bus address to store |
| port_count_i | input | NUM_PORTS*CNT_W | Per-port cell counts, port p at bits p*CNT_W upward |
| rd_req_o | output | 1 | Cell read request |
| rd_addr_o | output | ADDR_W | Cell read address |
| rd_len_o | output | LEN_W | Cell read length in bytes |
| rd_ack_i | input | 1 | Bus acknowledges the completed cell read |
| dec_pulse_o | output | NUM_PORTS | One-hot counter decrement |
| busy_o | output | 1 | A grant is in progress |
| empty_slot_o | output | 1 | Slot dropped, port had no cell |
| idx_err_o | output | 1 | Slot dropped, port number invalid |
| skip_o | output | 1 | Not a host stream, slot passed on |

## Verification
The bench builds the block with its defaults: six ports, a five-bit port field, five-bit counts and two alignment bits. Because the field is wider than the port count, indices 6 through 31 can reach the error path. A five-bit count lets the full value of 16 appear next to zero. The two alignment bits make it possible to see that unaligned table entries come out masked. Random connection words fill every bit outside the flag and the port field, so any leak of those bits into the outcome shows up.

// File: rtl/hpd_pkg.sv
package hpd_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_DECIDE = 2'd1,
      ST_REQ    = 2'd2
   } hpd_state_e;

   typedef enum logic [1:0] {
      OUT_SKIP  = 2'd0,
      OUT_ERR   = 2'd1,
      OUT_EMPTY = 2'd2,
      OUT_READ  = 2'd3
   } hpd_outcome_e;

endpackage

// File: rtl/hpd_conn_table.sv
module hpd_conn_table #(
   parameter int DEPTH  = 16,
   parameter int WORD_W = 32,
   localparam int IW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [IW-1:0]     widx_i,
   input  logic [WORD_W-1:0] wdata_i,
   input  logic [IW-1:0]     ridx_i,
   output logic [WORD_W-1:0] rdata_o
);

   if (DEPTH != (1 << IW)) begin : g_bad_depth
      $error("hpd_conn_table: DEPTH must be a power of two");
   end

   logic [WORD_W-1:0] ent [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [WORD_W-1:0] ent_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_q <= '0;
         end else if (we_i && (widx_i == IW'(i))) begin
            ent_q <= wdata_i;
         end
      end
      assign ent[i] = ent_q;
   end

   assign rdata_o = ent[ridx_i];

endmodule

// File: rtl/hpd_addr_table.sv
module hpd_addr_table #(
   parameter int NUM_PORTS  = 6,
   parameter int ADDR_W     = 32,
   parameter int SEL_W      = 5,
   parameter int ALIGN_BITS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we_i,
   input  logic [SEL_W-1:0]     widx_i,
   input  logic [ADDR_W-1:0]    wdata_i,
   input  logic [NUM_PORTS-1:0] sel_oh_i,
   output logic [ADDR_W-1:0]    addr_o
);

   if (ALIGN_BITS < 0 || ALIGN_BITS >= ADDR_W) begin : g_bad_align
      $error("hpd_addr_table: ALIGN_BITS out of range");
   end

   logic [ADDR_W-1:0] slot   [NUM_PORTS];
   logic [ADDR_W-1:0] picked [NUM_PORTS];
   logic [ADDR_W-1:0] raw;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic [ADDR_W-1:0] addr_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            addr_q <= '0;
         end else if (we_i && (widx_i == SEL_W'(p))) begin
            addr_q <= wdata_i;
         end
      end
      assign slot[p]   = addr_q;
      assign picked[p] = sel_oh_i[p] ? addr_q : '0;
   end

   always_comb begin
      raw = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         raw = raw | picked[p];
      end
   end

   if (ALIGN_BITS > 0) begin : g_align
      assign addr_o = {raw[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
      always_comb begin
         AST_ADDR_ALIGNED: assert (addr_o[ALIGN_BITS-1:0] == '0); // R9
      end
   end else begin : g_no_align
      assign addr_o = raw;
   end

endmodule

// File: rtl/hpd_port_select.sv
module hpd_port_select #(
   parameter int NUM_PORTS = 6,
   parameter int CNT_W     = 5,
   parameter int SEL_W     = 5
) (
   input  logic [NUM_PORTS*CNT_W-1:0] counts_i,
   input  logic [SEL_W-1:0]           sel_i,
   output logic [CNT_W-1:0]           count_o,
   output logic                       sel_valid_o,
   output logic [NUM_PORTS-1:0]       sel_oh_o
);

   logic [CNT_W-1:0] masked [NUM_PORTS];

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      assign sel_oh_o[p] = (sel_i == SEL_W'(p));
      assign masked[p]   = sel_oh_o[p] ? counts_i[p*CNT_W +: CNT_W] : '0;
   end

   always_comb begin
      count_o = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         count_o = count_o | masked[p];
      end
   end

   assign sel_valid_o = |sel_oh_o;

   always_comb begin
      AST_SEL_ONEHOT: assert ($onehot0(sel_oh_o)); // R6
   end

endmodule

// File: rtl/hpd_cell_dispatch.sv
module hpd_cell_dispatch
   import hpd_pkg::*;
#(
   parameter int NUM_PORTS  = 6,
   parameter int CONN_DEPTH = 16,
   parameter int WORD_W     = 32,
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 5,
   parameter int EN_BIT     = 21,
   parameter int PIDX_LO    = 26,
   parameter int PIDX_W     = 5,
   parameter int CELL_BYTES = 52,
   parameter int LEN_W      = 8,
   parameter int ALIGN_BITS = 2,
   localparam int CONN_IW   = $clog2(CONN_DEPTH)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ext_sched_i,
   input  logic                       grant_valid_i,
   input  logic [CONN_IW-1:0]         grant_conn_i,
   input  logic                       ctab_we_i,
   input  logic [CONN_IW-1:0]         ctab_idx_i,
   input  logic [WORD_W-1:0]          ctab_wdata_i,
   input  logic                       atab_we_i,
   input  logic [PIDX_W-1:0]          atab_idx_i,
   input  logic [ADDR_W-1:0]          atab_wdata_i,
   input  logic [NUM_PORTS*CNT_W-1:0] port_count_i,
   output logic                       rd_req_o,
   output logic [ADDR_W-1:0]          rd_addr_o,
   output logic [LEN_W-1:0]           rd_len_o,
   input  logic                       rd_ack_i,
   output logic [NUM_PORTS-1:0]       dec_pulse_o,
   output logic                       busy_o,
   output logic                       empty_slot_o,
   output logic                       idx_err_o,
   output logic                       skip_o
);

   // ---------------- elaboration checks ----------------
   if (EN_BIT < 0 || EN_BIT >= WORD_W) begin : g_bad_en
      $error("hpd_cell_dispatch: EN_BIT outside the word");
   end
   if (PIDX_LO < 0 || PIDX_LO + PIDX_W > WORD_W) begin : g_bad_field
      $error("hpd_cell_dispatch: port field outside the word");
   end
   if (EN_BIT >= PIDX_LO && EN_BIT < PIDX_LO + PIDX_W) begin : g_overlap
      $error("hpd_cell_dispatch: flag bit overlaps port field");
   end
   if (NUM_PORTS < 1 || NUM_PORTS > (1 << PIDX_W)) begin : g_bad_ports
      $error("hpd_cell_dispatch: NUM_PORTS does not fit the port field");
   end
   if (CELL_BYTES < 1 || CELL_BYTES >= (1 << LEN_W)) begin : g_bad_len
      $error("hpd_cell_dispatch: CELL_BYTES does not fit LEN_W");
   end

   // ---------------- state ----------------
   hpd_state_e            state_q;
   logic [WORD_W-1:0]     word_q;
   logic [WORD_W-1:0]     word_rd;
   logic [NUM_PORTS-1:0]  port_oh_q;
   logic [ADDR_W-1:0]     addr_q;
   logic [NUM_PORTS-1:0]  dec_q;
   logic                  empty_q, err_q, skip_q;

   // ---------------- tables ----------------
   hpd_conn_table #(
      .DEPTH  (CONN_DEPTH),
      .WORD_W (WORD_W)
   ) u_conn (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (ctab_we_i),
      .widx_i  (ctab_idx_i),
      .wdata_i (ctab_wdata_i),
      .ridx_i  (grant_conn_i),
      .rdata_o (word_rd)
   );

   logic                 host_c;
   logic [PIDX_W-1:0]    pidx_c;
   logic [CNT_W-1:0]     cnt_c;
   logic                 pvalid_c;
   logic [NUM_PORTS-1:0] poh_c;
   logic [ADDR_W-1:0]    paddr_c;
   hpd_outcome_e         outcome_c;

   assign host_c = word_q[EN_BIT] & ~ext_sched_i;
   assign pidx_c = word_q[PIDX_LO +: PIDX_W];

   hpd_port_select #(
      .NUM_PORTS (NUM_PORTS),
      .CNT_W     (CNT_W),
      .SEL_W     (PIDX_W)
   ) u_sel (
      .counts_i    (port_count_i),
      .sel_i       (pidx_c),
      .count_o     (cnt_c),
      .sel_valid_o (pvalid_c),
      .sel_oh_o    (poh_c)
   );

   hpd_addr_table #(
      .NUM_PORTS  (NUM_PORTS),
      .ADDR_W     (ADDR_W),
      .SEL_W      (PIDX_W),
      .ALIGN_BITS (ALIGN_BITS)
   ) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_i     (atab_we_i),
      .widx_i   (atab_idx_i),
      .wdata_i  (atab_wdata_i),
      .sel_oh_i (poh_c),
      .addr_o   (paddr_c)
   );

   // ---------------- decision ----------------
   always_comb begin
      if (!host_c) begin
         outcome_c = OUT_SKIP;
      end else if (!pvalid_c) begin
         outcome_c = OUT_ERR;
      end else if (cnt_c == '0) begin
         outcome_c = OUT_EMPTY;
      end else begin
         outcome_c = OUT_READ;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         word_q    <= '0;
         port_oh_q <= '0;
         addr_q    <= '0;
         dec_q     <= '0;
         empty_q   <= 1'b0;
         err_q     <= 1'b0;
         skip_q    <= 1'b0;
      end else begin
         dec_q   <= '0;
         empty_q <= 1'b0;
         err_q   <= 1'b0;
         skip_q  <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (grant_valid_i) begin
                  word_q  <= word_rd;
                  state_q <= ST_DECIDE;
               end
            end
            ST_DECIDE: begin
               unique case (outcome_c)
                  OUT_SKIP: begin
                     skip_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end
                  OUT_ERR: begin
                     err_q   <= 1'b1;
                     state_q <= ST_IDLE;
                  end
                  OUT_EMPTY: begin
                     empty_q <= 1'b1;
                     state_q <= ST_IDLE;
                  end
                  OUT_READ: begin
                     port_oh_q <= poh_c;
                     addr_q    <= paddr_c;
                     state_q   <= ST_REQ;
                  end
                  default: state_q <= ST_IDLE;
               endcase
            end
            ST_REQ: begin
               if (rd_ack_i) begin
                  dec_q   <= port_oh_q;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign rd_req_o     = (state_q == ST_REQ);
   assign rd_addr_o    = addr_q;
   assign rd_len_o     = LEN_W'(CELL_BYTES);
   assign dec_pulse_o  = dec_q;
   assign busy_o       = (state_q != ST_IDLE);
   assign empty_slot_o = empty_q;
   assign idx_err_o    = err_q;
   assign skip_o       = skip_q;

   // ---------------- assertions ----------------
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o))); // R3
   AST_DEC_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (|dec_pulse_o) |-> $past(rd_req_o && rd_ack_i)); // R4
   AST_DEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (|dec_pulse_o) |=> (dec_pulse_o == '0)); // R4
   AST_DEC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dec_pulse_o)); // R4
   AST_EMPTY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      empty_slot_o |-> (!rd_req_o && dec_pulse_o == '0)); // R5
   AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      idx_err_o |-> (!rd_req_o && dec_pulse_o == '0)); // R6
   AST_SKIP_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      skip_o |-> (!rd_req_o && !idx_err_o && !empty_slot_o)); // R7
   AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |-> busy_o); // R8
   AST_GRANT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid_i && !busy_o) |=> busy_o); // R8

endmodule

// File: tb/tb_hpd_cell_dispatch.sv
module tb_hpd_cell_dispatch;

   localparam int NP = 6;
   localparam int CW = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_sched_i = 1'b0;
   logic        grant_valid_i = 1'b0;
   logic [3:0]  grant_conn_i = '0;
   logic        ctab_we_i = 1'b0;
   logic [3:0]  ctab_idx_i = '0;
   logic [31:0] ctab_wdata_i = '0;
   logic        atab_we_i = 1'b0;
   logic [4:0]  atab_idx_i = '0;
   logic [31:0] atab_wdata_i = '0;
   logic [NP*CW-1:0] port_count_i = '0;
   logic        rd_req_o;
   logic [31:0] rd_addr_o;
   logic [7:0]  rd_len_o;
   logic        rd_ack_i = 1'b0;
   logic [NP-1:0] dec_pulse_o;
   logic        busy_o, empty_slot_o, idx_err_o, skip_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [31:0] conn_m [16];
   logic [31:0] addr_m [NP];

   always #5 clk = ~clk;

   hpd_cell_dispatch dut (
      .clk(clk), .rst_n(rst_n), .ext_sched_i(ext_sched_i),
      .grant_valid_i(grant_valid_i), .grant_conn_i(grant_conn_i),
      .ctab_we_i(ctab_we_i), .ctab_idx_i(ctab_idx_i), .ctab_wdata_i(ctab_wdata_i),
      .atab_we_i(atab_we_i), .atab_idx_i(atab_idx_i), .atab_wdata_i(atab_wdata_i),
      .port_count_i(port_count_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
      .rd_len_o(rd_len_o), .rd_ack_i(rd_ack_i), .dec_pulse_o(dec_pulse_o),
      .busy_o(busy_o), .empty_slot_o(empty_slot_o), .idx_err_o(idx_err_o),
      .skip_o(skip_o)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // outcome: 0 skip, 1 error, 2 empty, 3 read
   function automatic int exp_outcome(input logic [31:0] w, input logic ext);
      int idx;
      idx = int'(w[30:26]);
      if (!w[21] || ext) return 0;
      if (idx >= NP) return 1;
      if (port_count_i[idx*CW +: CW] == '0) return 2;
      return 3;
   endfunction

   function automatic logic [31:0] make_word(input bit flag, input int idx, input logic [31:0] junk);
      return (junk & ~32'h7C20_0000) | (32'(flag) << 21) | (32'(idx & 31) << 26);
   endfunction

   task automatic wr_conn(input int i, input logic [31:0] w);
      @(negedge clk);
      ctab_we_i = 1'b1; ctab_idx_i = 4'(i); ctab_wdata_i = w;
      @(negedge clk);
      ctab_we_i = 1'b0;
      conn_m[i] = w;
   endtask

   task automatic wr_addr(input int i, input logic [31:0] a);
      @(negedge clk);
      atab_we_i = 1'b1; atab_idx_i = 5'(i); atab_wdata_i = a;
      @(negedge clk);
      atab_we_i = 1'b0;
      if (i < NP) addr_m[i] = a;
   endtask

   task automatic grant(input int conn, input int ack_wait, input bit inject);
      int kind;
      int idx;
      logic [31:0] ea;
      @(negedge clk);
      grant_valid_i = 1'b1; grant_conn_i = 4'(conn);
      @(negedge clk);
      grant_valid_i = 1'b0;
      chk("R8 busy after grant", 64'(busy_o), 64'd1);
      chk("R2 no early request", 64'(rd_req_o), 64'd0);
      kind = exp_outcome(conn_m[conn], ext_sched_i);
      idx = int'(conn_m[conn][30:26]);
      @(negedge clk);
      chk("R7 skip pulse", 64'(skip_o), 64'(kind == 0));
      chk("R6 error pulse", 64'(idx_err_o), 64'(kind == 1));
      chk("R5 empty pulse", 64'(empty_slot_o), 64'(kind == 2));
      chk("R2 request", 64'(rd_req_o), 64'(kind == 3));
      if (kind != 3) begin
         chk("R8 busy ends with status", 64'(busy_o), 64'd0);
         chk("R5 no decrement", 64'(dec_pulse_o), 64'd0);
         @(negedge clk);
         chk("R5 status one cycle", 64'({skip_o, idx_err_o, empty_slot_o}), 64'd0);
      end else begin
         ea = addr_m[idx] & ~32'h3;
         chk("R2 R9 address", 64'(rd_addr_o), 64'(ea));
         chk("R2 length", 64'(rd_len_o), 64'd52);
         for (int w = 0; w < ack_wait; w++) begin
            if (inject && w == 0) begin
               grant_valid_i = 1'b1; grant_conn_i = 4'((conn + 1) % 16);
            end
            @(negedge clk);
            grant_valid_i = 1'b0;
            chk("R3 request held", 64'(rd_req_o), 64'd1);
            chk("R3 address stable", 64'(rd_addr_o), 64'(ea));
            chk("R4 no early decrement", 64'(dec_pulse_o), 64'd0);
         end
         rd_ack_i = 1'b1;
         @(negedge clk);
         rd_ack_i = 1'b0;
         chk("R4 decrement onehot", 64'(dec_pulse_o), 64'(1) << idx);
         chk("R4 request drops", 64'(rd_req_o), 64'd0);
         chk("R8 busy drops", 64'(busy_o), 64'd0);
         @(negedge clk);
         chk("R4 decrement one cycle", 64'(dec_pulse_o), 64'd0);
         chk("R8 busy grant ignored", 64'(busy_o), 64'd0);
      end
   endtask

   task automatic set_count(input int p, input int v);
      port_count_i[p*CW +: CW] = CW'(v);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int s;
      s = $urandom(1234);
      for (int i = 0; i < 16; i++) conn_m[i] = '0;
      for (int i = 0; i < NP; i++) addr_m[i] = '0;
      repeat (3) @(negedge clk);
      chk("R1 busy", 64'(busy_o), 64'd0);
      chk("R1 request", 64'(rd_req_o), 64'd0);
      chk("R1 pulses", 64'({dec_pulse_o, empty_slot_o, idx_err_o, skip_o}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", 64'({busy_o, rd_req_o, dec_pulse_o, empty_slot_o, idx_err_o, skip_o}), 64'd0);
      // R1: empty table gives flag clear, so a skip
      grant(3, 0, 0);

      for (int p = 0; p < NP; p++) begin
         wr_addr(p, 32'h1000_0000 + 32'(p * 32'h100) + 32'(p % 4));
         set_count(p, p + 1);
      end
      wr_addr(7, 32'hDEAD_BEEF);  // out of range, dropped

      // R2 every port, R9 unaligned entries
      for (int p = 0; p < NP; p++) begin
         wr_conn(p, make_word(1'b1, p, 32'h0));
         grant(p, p % 3, p == 2);
      end
      // R5 zero count
      set_count(4, 0);
      grant(4, 0, 0);
      // R2 full count 16
      set_count(4, 16);
      grant(4, 1, 0);
      // R6 indices 6, 7, 31
      wr_conn(8, make_word(1'b1, 6, 32'h0)); grant(8, 0, 0);
      wr_conn(9, make_word(1'b1, 7, 32'h0)); grant(9, 0, 0);
      wr_conn(10, make_word(1'b1, 31, 32'hFFFF_FFFF)); grant(10, 0, 0);
      // R7 flag clear with invalid index; ext_sched high with valid index
      wr_conn(11, make_word(1'b0, 31, 32'h0)); grant(11, 0, 0);
      ext_sched_i = 1'b1;
      grant(1, 0, 0);
      grant(10, 0, 0);
      ext_sched_i = 1'b0;
      // R10 junk bits
      wr_conn(12, make_word(1'b1, 5, 32'hFFFF_FFFF)); grant(12, 2, 1);

      // random mix
      for (int it = 0; it < 80; it++) begin
         int c;
         c = int'($urandom_range(15, 0));
         wr_conn(c, make_word(1'($urandom_range(3, 0) != 0), int'($urandom_range(7, 0)), $urandom()));
         for (int p = 0; p < NP; p++) begin
            set_count(p, ($urandom_range(3, 0) == 0) ? 0 : int'($urandom_range(16, 1)));
         end
         if ($urandom_range(4, 0) == 0) wr_addr(int'($urandom_range(5, 0)), $urandom());
         ext_sched_i = ($urandom_range(5, 0) == 0);
         grant(c, int'($urandom_range(3, 0)), 1'($urandom_range(1, 0)));
         ext_sched_i = 1'b0;
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule